// File: doc/BRIEF.md
# Key-Protected Clock Control Register

This block holds the clock-system control settings of a chip: a two-bit system clock ratio, a prescaler run bit, a selector that picks the high-speed or the low-speed source for the CPU, and run bits for the high-speed and low-speed oscillators. These fields sit behind a guard register. A control write is accepted only while the guard holds the 8-bit unlock key 0x96. Writing any other value to the guard locks the fields again. A control write that arrives while the fields are locked changes nothing. It raises a one-cycle reject flag that test logic can observe.

The block also contains the system clock divider. The divider turns the ratio field into a CPU clock-enable pulse at 1/1, 1/2, 1/4 or 1/8 of the input clock. A new ratio does not cut the running period short. The divider picks up the new ratio only when the current divided period ends.

Software reaches the block through one byte-wide port. `addr` 0 selects the control register and `addr` 1 selects the guard register. The read data is combinational and follows `addr`.

Top module: `clkctl_top`

## Requirements
- R1: After reset the guard reads 0x00, the control register reads 0x27, and a control write is rejected.
- R2: Writing 0x96 to the guard (addr 1) unlocks the control register, so the next control write (addr 0) stores its data.
- R3: Writing any value other than 0x96 to the guard locks the control register again, and the guard always reads back the last value written to it.
- R4: A control write made while locked leaves every field and the control read-back unchanged.
- R5: A control write made while locked sets `wr_reject` for exactly the one cycle after the write. Accepted writes and guard writes never set it.
- R6: Control bits 4 and 3 are reserved. Writes to them are ignored and they always read back as 0.
- R7: The control layout is: bits 7:6 hold the ratio (`div_sel`), bit 5 the prescaler run bit, bit 2 the CPU source (1 = high-speed), bit 1 the high-speed oscillator run bit and bit 0 the low-speed oscillator run bit. Each field drives its output port directly.
- R8: `cpu_clk_en` pulses once every 1, 2, 4 or 8 cycles for ratio codes 00, 01, 10 and 11. Under code 00 it is high in every cycle.
- R9: A change of the ratio takes effect only at the end of the divided period that is running when the change is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 1 | 0 = control register, 1 = guard register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| div_sel | output | 2 | System clock ratio field |
| presc_on | output | 1 | Prescaler run bit |
| cpu_src_hs | output | 1 | CPU clock source, 1 = high-speed |
| hs_osc_en | output | 1 | High-speed oscillator run bit |
| ls_osc_en | output | 1 | Low-speed oscillator run bit |
| wr_reject | output | 1 | One-cycle flag for a rejected control write |
| cpu_clk_en | output | 1 | CPU clock-enable pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, the key 0x96 and a 2-bit ratio field. With these values every ratio code, every reserved bit and the exact unlock key can be driven directly. A table walks through pairs of key and control writes. It covers the exact key, the keys next to it (0x97) and other wrong values, and writes with all bits set, so that locking, re-locking and reserved-bit masking are all exercised. Directed tests then measure the pulse rate of each ratio. One test changes the ratio from 1/8 to 1/1 just after a pulse and checks that the long period still completes before the new ratio applies.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int DATA_W    = 8;
  localparam int RATIO_W   = 2;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'h96;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               presc_on;
    logic               cpu_hs;
    logic               hs_run;
    logic               ls_run;
  } clk_fields_t;

  localparam clk_fields_t FIELDS_RST = '{
    ratio:    '0,
    presc_on: 1'b1,
    cpu_hs:   1'b1,
    hs_run:   1'b1,
    ls_run:   1'b1
  };

  function automatic clk_fields_t unpack_ctl(input logic [DATA_W-1:0] d);
    clk_fields_t f;
    f.ratio    = d[7:6];
    f.presc_on = d[5];
    f.cpu_hs   = d[2];
    f.hs_run   = d[1];
    f.ls_run   = d[0];
    return f;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctl(input clk_fields_t f);
    logic [DATA_W-1:0] d;
    d      = '0;
    d[7:6] = f.ratio;
    d[5]   = f.presc_on;
    d[2]   = f.cpu_hs;
    d[1]   = f.hs_run;
    d[0]   = f.ls_run;
    return d;
  endfunction

endpackage

// File: rtl/clkctl_key_guard.sv
module clkctl_key_guard #(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY = 8'h96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] key_q,
  output logic          unlocked
);

  logic [DW-1:0] key_d;

  always_comb begin
    key_d = key_q;
    if (we) key_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  assign unlocked = (key_q == KEY);

  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata == KEY) |=> unlocked);

  a_r3_other_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata != KEY) |=> !unlocked);

  a_r3_guard_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(key_q));

endmodule

// File: rtl/clkctl_fields.sv
module clkctl_fields
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] wdata,
  output clk_fields_t       fields_q,
  output logic              reject_q
);

  clk_fields_t fields_d;
  logic        accept;
  logic        reject_d;

  always_comb begin
    accept   = we && unlocked;
    reject_d = we && !unlocked;
    fields_d = fields_q;
    if (accept) fields_d = unpack_ctl(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= FIELDS_RST;
      reject_q <= 1'b0;
    end else begin
      fields_q <= fields_d;
      reject_q <= reject_d;
    end
  end

  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !unlocked) |=> $stable(fields_q));

  a_r5_reject_set: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !unlocked) |=> reject_q);

  a_r5_reject_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && !unlocked) |=> !reject_q);

  a_r2_accept_store: assert property (@(posedge clk) disable iff (!rst_n)
    (we && unlocked) |=> (fields_q.ratio == $past(wdata[7:6])));

endmodule

// File: rtl/clkctl_sysdiv.sv
module clkctl_sysdiv #(
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  output logic          clk_en
);

  localparam int CNT_W = (1 << RW) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RW-1:0]    act_q, act_d;
  logic [CNT_W-1:0] lim;
  logic             boundary;

  always_comb begin
    lim = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(act_q)) lim[i] = 1'b1;
    end
    boundary = (cnt_q == lim);
    cnt_d    = cnt_q + 1'b1;
    act_d    = act_q;
    if (boundary) begin
      cnt_d = '0;
      act_d = ratio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign clk_en = (cnt_q == '0);

  a_r9_ratio_held_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_q));

  a_r8_wrap_to_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> clk_en);

  a_r8_no_pulse_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> !clk_en);

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int RW = RATIO_W,
  parameter logic [DW-1:0] KEY = UNLOCK_KEY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [RW-1:0] div_sel,
  output logic          presc_on,
  output logic          cpu_src_hs,
  output logic          hs_osc_en,
  output logic          ls_osc_en,
  output logic          wr_reject,
  output logic          cpu_clk_en
);

  localparam logic ADDR_CTL   = 1'b0;
  localparam logic ADDR_GUARD = 1'b1;

  logic [DW-1:0] key_q;
  logic          unlocked;
  clk_fields_t   fields;
  logic          guard_we, ctl_we;

  assign guard_we = wr_en && (addr == ADDR_GUARD);
  assign ctl_we   = wr_en && (addr == ADDR_CTL);

  clkctl_key_guard #(.DW(DW), .KEY(KEY)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (guard_we),
    .wdata    (wdata),
    .key_q    (key_q),
    .unlocked (unlocked)
  );

  clkctl_fields u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctl_we),
    .unlocked (unlocked),
    .wdata    (wdata),
    .fields_q (fields),
    .reject_q (wr_reject)
  );

  clkctl_sysdiv #(.RW(RW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .ratio  (fields.ratio),
    .clk_en (cpu_clk_en)
  );

  always_comb begin
    if (addr == ADDR_GUARD) rdata = key_q;
    else                    rdata = pack_ctl(fields);
  end

  assign div_sel    = fields.ratio;
  assign presc_on   = fields.presc_on;
  assign cpu_src_hs = fields.cpu_hs;
  assign hs_osc_en  = fields.hs_run;
  assign ls_osc_en  = fields.ls_run;

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_CTL) |-> (rdata[4:3] == 2'b00));

  a_r3_guard_write_no_reject: assert property (@(posedge clk) disable iff (!rst_n)
    guard_we |=> !wr_reject);

endmodule

// File: tb/clkctl_top_test.sv
module clkctl_top_test;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, wr_en, addr;
  logic [7:0] wdata, rdata;
  logic [1:0] div_sel;
  logic       presc_on, cpu_src_hs, hs_osc_en, ls_osc_en, wr_reject, cpu_clk_en;

  int n_run, n_fail;

  clkctl_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .div_sel(div_sel), .presc_on(presc_on),
    .cpu_src_hs(cpu_src_hs), .hs_osc_en(hs_osc_en), .ls_osc_en(ls_osc_en),
    .wr_reject(wr_reject), .cpu_clk_en(cpu_clk_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [7:0] key;
    logic [7:0] wd;
    logic [7:0] exp_rd;
    logic       exp_rej;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{key: 8'h96, wd: 8'hE4, exp_rd: 8'hE4, exp_rej: 1'b0},
    '{key: 8'h00, wd: 8'h00, exp_rd: 8'hE4, exp_rej: 1'b1},
    '{key: 8'h96, wd: 8'h1B, exp_rd: 8'h03, exp_rej: 1'b0},
    '{key: 8'h97, wd: 8'hFF, exp_rd: 8'h03, exp_rej: 1'b1},
    '{key: 8'h96, wd: 8'hFF, exp_rd: 8'hE7, exp_rej: 1'b0},
    '{key: 8'h69, wd: 8'h00, exp_rd: 8'hE7, exp_rej: 1'b1},
    '{key: 8'h96, wd: 8'h40, exp_rd: 8'h40, exp_rej: 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b1, r); check("R1 guard reset", r, 8'h00);
    rd(1'b0, r); check("R1 ctl reset", r, 8'h27);
    check("R1 reset reject", wr_reject, 0);
    wr(1'b0, 8'hC0);
    check("R1 locked after reset reject", wr_reject, 1);
    rd(1'b0, r); check("R1 locked after reset hold", r, 8'h27);
    @(negedge clk);
    check("R5 reject one cycle", wr_reject, 0);

    // table: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b1, VECS[i].key);
      check("R5 guard write no reject", wr_reject, 0);
      rd(1'b1, r); check("R3 guard readback", r, VECS[i].key);
      wr(1'b0, VECS[i].wd);
      check(VECS[i].exp_rej ? "R5 locked reject" : "R2 accepted no reject",
            wr_reject, VECS[i].exp_rej);
      rd(1'b0, r);
      check(VECS[i].exp_rej ? "R4 locked hold" : "R6 stored masked", r, VECS[i].exp_rd);
      if (i == 0) begin
        check("R7 div_sel", div_sel, 2'b11);
        check("R7 presc_on", presc_on, 1);
        check("R7 cpu_src_hs", cpu_src_hs, 1);
        check("R7 hs_osc_en", hs_osc_en, 0);
        check("R7 ls_osc_en", ls_osc_en, 0);
      end
    end

    // R8 pulse rates (still unlocked)
    for (int c = 0; c < 4; c++) begin
      int cnt;
      wr(1'b0, {c[1:0], 6'b100111});
      repeat (16) @(negedge clk);
      cnt = 0;
      for (int k = 0; k < 32; k++) begin
        if (cpu_clk_en) cnt++;
        @(negedge clk);
      end
      check("R8 pulse count", cnt, 32 >> c);
    end

    // R9 change from 1/8 to 1/1 right after a pulse
    wr(1'b0, 8'hE7);
    repeat (16) @(negedge clk);
    while (!cpu_clk_en) @(negedge clk);
    wr_en = 1'b1; addr = 1'b0; wdata = 8'h27;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (k < 8) check("R9 old period completes", cpu_clk_en, 0);
      else       check("R9 new ratio applied", cpu_clk_en, 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule